// File: doc/BRIEF.md
# Type 0 Configuration-Space Target

This block answers configuration transactions for a single-function device on a parallel local bus. It watches the address phase, decides whether a cycle belongs to it, and then either serves one dword of its register file or turns the initiator away. Until local firmware sets the init-done input, every cycle that would otherwise be claimed gets a retry. This gives the local side time to set itself up before a host enumerates the device.

The interface works at cycle level with active-high strobes. `frame` and `irdy` come from the initiator. `devsel`, `trdy` and `stop` go back to it. `cbe` carries the command during the address phase and active-low byte enables during the data phase. The register space has 64 dwords. Four of them hold state: a fixed identity word, a command word, and two base address registers. Every other dword reads as zero and drops writes, so the header reads as Type 0 with a single function. An access is always one dword. An initiator that tries to burst is disconnected after the first transfer.

Top module: `cfg_target`

## Requirements
- R1: While `init_done` is 0, a cycle that meets the claim conditions gets a retry. In the first cycle after the address phase, `devsel` and `stop` are 1 and `trdy` is 0. They hold until `frame` is low. No register changes.
- R2: While `init_done` is 1, a claimed cycle has `devsel` and `trdy` high in the first cycle after the address phase. The transfer completes in the first cycle where `irdy` is also high.
- R3: A cycle is claimed only when all of these hold in the address phase: `idsel` is 1, `cbe` is 4'b1010 (read) or 4'b1011 (write), and `ad_in[1:0]` is 2'b00. Any other cycle leaves `devsel`, `trdy` and `stop` at 0 and changes no register.
- R4: The dword selected is `ad_in[7:2]` as sampled in the address phase.
- R5: If `frame` is still high during the data transfer, `stop` is raised together with `trdy`. After the transfer, `devsel` and `stop` stay high with `trdy` low until `frame` falls. Only the first dword is written.
- R6: A read drives all 32 bits of the selected dword on `ad_out`, whatever the byte enables are.
- R7: A read of any dword other than 0, 1, 4 and 5 completes with `trdy` and returns 0. This includes dword 3, which makes the header type byte 0: Type 0, single function.
- R8: A write changes only the byte lanes whose enable bit in `cbe` is 0. Bit k covers bits 8k+7..8k.
- R9: Writes to dword 0 and to unimplemented dwords complete with `trdy` and leave every readable value unchanged.
- R10: Dword 0 reads {DEVICE_ID, VENDOR_ID}, with defaults 16'h7C21 and 16'h1AB5. In dword 1, only the bits in CMD_WMASK (16'h0547) can be written, and bits 31:16 read 0. In dwords 4 and 5, only the bits in BAR_MASK (32'hFFFF_F000) can be written, and the rest read 0.
- R11: After reset, `devsel`, `trdy` and `stop` are 0, and dwords 1, 4 and 5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_done | input | 1 | Local initialization finished; enables acceptance |
| idsel | input | 1 | Device select for configuration cycles |
| frame | input | 1 | Initiator cycle strobe, active high |
| irdy | input | 1 | Initiator ready, active high |
| cbe | input | 4 | Command (address phase) / active-low byte enables (data phase) |
| ad_in | input | 32 | Address (address phase) / write data (data phase) |
| ad_out | output | 32 | Read data, valid while `trdy` is high on a read |
| trdy | output | 1 | Target ready |
| stop | output | 1 | Target stop request (retry or disconnect) |
| devsel | output | 1 | Target claims the cycle |

## Verification
The assertions assume a well-behaved initiator. It starts an address phase only while the target is idle. It keeps `frame` low once it has dropped it. It raises `frame` only when a cycle begins. The bench follows these rules by running every access through one task. That task drives a fixed address-phase, data-phase and end sequence, leaves one idle cycle between accesses, and changes `init_done` only between accesses.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_RETRY,
        ST_DISC
    } tgt_state_e;

    typedef struct packed {
        logic       hit;
        logic       wr;
        logic [5:0] idx;
    } addr_dec_t;

    // Expand active-low byte enables to a 32-bit lane mask
    function automatic logic [31:0] lane_mask(input logic [3:0] be_n);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) begin
            m[8*k +: 8] = {8{~be_n[k]}};
        end
        return m;
    endfunction

    // Merge write data into an old value under lane and writability masks
    function automatic logic [31:0] merge_write(input logic [31:0] old_v,
                                                input logic [31:0] wdata,
                                                input logic [3:0]  be_n,
                                                input logic [31:0] wmask);
        logic [31:0] sel;
        sel = lane_mask(be_n) & wmask;
        return (old_v & ~sel) | (wdata & sel);
    endfunction

endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_pkg::*;
(
    input  logic       idsel,
    input  logic [3:0] cmd,
    input  logic [7:0] ad_lo,
    output addr_dec_t  dec
);
    logic is_rd;
    logic is_wr;

    always_comb begin
        is_rd   = (cmd == CMD_CFG_RD);
        is_wr   = (cmd == CMD_CFG_WR);
        dec.hit = idsel && (is_rd || is_wr) && (ad_lo[1:0] == 2'b00);
        dec.wr  = is_wr;
        dec.idx = ad_lo[7:2];
    end
endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
    import cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame,
    input  logic       irdy,
    input  logic       init_done,
    input  addr_dec_t  dec,
    output logic       devsel,
    output logic       trdy,
    output logic       stop,
    output logic       idle,
    output logic [5:0] cur_idx,
    output logic       cur_wr,
    output logic       wr_en
);
    tgt_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cur_idx <= '0;
            cur_wr  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (frame && dec.hit) begin
                        st      <= init_done ? ST_XFER : ST_RETRY;
                        cur_idx <= dec.idx;
                        cur_wr  <= dec.wr;
                    end
                end
                ST_XFER: begin
                    if (irdy) st <= frame ? ST_DISC : ST_IDLE;
                end
                ST_RETRY: begin
                    if (!frame) st <= ST_IDLE;
                end
                ST_DISC: begin
                    if (!frame) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle   = (st == ST_IDLE);
        devsel = (st != ST_IDLE);
        trdy   = (st == ST_XFER);
        stop   = (st == ST_RETRY) || (st == ST_DISC) || ((st == ST_XFER) && frame);
        wr_en  = (st == ST_XFER) && irdy && cur_wr;
    end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1AB5,
    parameter logic [15:0] DEVICE_ID = 16'h7C21,
    parameter logic [15:0] CMD_WMASK = 16'h0547,
    parameter logic [31:0] BAR_MASK  = 32'hFFFF_F000,
    parameter int          NUM_BARS  = 2,
    parameter int          BAR_FIRST = 4,
    parameter int          IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    input  logic [3:0]       be_n,
    output logic [31:0]      rdata
);
    localparam logic [IDX_W-1:0] IDX_ID  = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_CMD = IDX_W'(1);

    logic [15:0] cmd_q;
    logic [31:0] bar_q [NUM_BARS];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (wr_en && idx == IDX_CMD) begin
            cmd_q <= merge_write({16'h0, cmd_q}, wdata, be_n, {16'h0, CMD_WMASK})
                     [15:0];
        end
    end

    for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(BAR_FIRST + b);
        always_ff @(posedge clk) begin
            if (rst) begin
                bar_q[b] <= '0;
            end else if (wr_en && idx == MY_IDX) begin
                bar_q[b] <= merge_write(bar_q[b], wdata, be_n, BAR_MASK);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (idx == IDX_ID)  rdata = {DEVICE_ID, VENDOR_ID};
        if (idx == IDX_CMD) rdata = {16'h0, cmd_q};
        for (int b = 0; b < NUM_BARS; b++) begin
            if (idx == IDX_W'(BAR_FIRST + b)) rdata = bar_q[b];
        end
    end
endmodule

// File: rtl/cfg_target.sv
module cfg_target
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1AB5,
    parameter logic [15:0] DEVICE_ID = 16'h7C21,
    parameter logic [15:0] CMD_WMASK = 16'h0547,
    parameter logic [31:0] BAR_MASK  = 32'hFFFF_F000,
    parameter int          NUM_BARS  = 2,
    parameter int          BAR_FIRST = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        init_done,
    input  logic        idsel,
    input  logic        frame,
    input  logic        irdy,
    input  logic [3:0]  cbe,
    input  logic [31:0] ad_in,
    output logic [31:0] ad_out,
    output logic        trdy,
    output logic        stop,
    output logic        devsel
);
    localparam int CFG_DWORDS = 64;
    localparam int IDX_W      = $clog2(CFG_DWORDS);

    addr_dec_t   dec;
    logic        fsm_idle;
    logic [5:0]  cur_idx;
    logic        cur_wr;
    logic        wr_en;
    logic [31:0] rdata;

    cfg_decode u_dec (
        .idsel (idsel),
        .cmd   (cbe),
        .ad_lo (ad_in[7:0]),
        .dec   (dec)
    );

    cfg_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .frame     (frame),
        .irdy      (irdy),
        .init_done (init_done),
        .dec       (dec),
        .devsel    (devsel),
        .trdy      (trdy),
        .stop      (stop),
        .idle      (fsm_idle),
        .cur_idx   (cur_idx),
        .cur_wr    (cur_wr),
        .wr_en     (wr_en)
    );

    cfg_regfile #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID),
        .CMD_WMASK (CMD_WMASK),
        .BAR_MASK  (BAR_MASK),
        .NUM_BARS  (NUM_BARS),
        .BAR_FIRST (BAR_FIRST),
        .IDX_W     (IDX_W)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .idx   (IDX_W'(cur_idx)),
        .wdata (ad_in),
        .be_n  (cbe),
        .rdata (rdata)
    );

    assign ad_out = (trdy && !cur_wr) ? rdata : '0;
endmodule

// File: rtl/cfg_target_chk.sv
module cfg_target_chk
    import cfg_pkg::*;
#(
    parameter int NUM_BARS  = 2,
    parameter int BAR_FIRST = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        init_done,
    input logic        idsel,
    input logic        frame,
    input logic [3:0]  cbe,
    input logic [1:0]  ad_type,
    input logic [31:0] ad_out,
    input logic        trdy,
    input logic        stop,
    input logic        devsel,
    input logic        fsm_idle,
    input logic [5:0]  cur_idx,
    input logic        cur_wr
);
    logic hit;
    logic impl;

    always_comb begin
        hit  = idsel && (cbe == CMD_CFG_RD || cbe == CMD_CFG_WR) && (ad_type == 2'b00);
        impl = (cur_idx == 6'd0) || (cur_idx == 6'd1) ||
               ((int'(cur_idx) >= BAR_FIRST) && (int'(cur_idx) < BAR_FIRST + NUM_BARS));
    end

    p_retry_r1: assert property (@(posedge clk) disable iff (rst)
        fsm_idle && frame && hit && !init_done |=> devsel && stop && !trdy);

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        fsm_idle && frame && hit && init_done |=> devsel && trdy);

    p_trdy_claimed_r2: assert property (@(posedge clk) disable iff (rst)
        trdy |-> devsel);

    p_no_claim_r3: assert property (@(posedge clk) disable iff (rst)
        fsm_idle && frame && !hit |=> !devsel && !trdy && !stop);

    p_burst_disc_r5: assert property (@(posedge clk) disable iff (rst)
        trdy && frame |-> stop);

    p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (rst)
        trdy && !cur_wr && !impl |-> ad_out == 32'h0);
endmodule

bind cfg_target cfg_target_chk #(
    .NUM_BARS  (NUM_BARS),
    .BAR_FIRST (BAR_FIRST)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .init_done (init_done),
    .idsel     (idsel),
    .frame     (frame),
    .cbe       (cbe),
    .ad_type   (ad_in[1:0]),
    .ad_out    (ad_out),
    .trdy      (trdy),
    .stop      (stop),
    .devsel    (devsel),
    .fsm_idle  (fsm_idle),
    .cur_idx   (cur_idx),
    .cur_wr    (cur_wr)
);

// File: tb/tb_cfg_target.sv
`timescale 1ns/1ps
module tb_cfg_target;

    localparam logic [3:0]  RD = 4'b1010;
    localparam logic [3:0]  WR = 4'b1011;
    localparam logic [31:0] ID_WORD = 32'h7C21_1AB5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_done = 1'b0;
    logic        idsel = 1'b0;
    logic        frame = 1'b0;
    logic        irdy = 1'b0;
    logic [3:0]  cbe = 4'hF;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic        trdy, stop, devsel;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] model [64];

    logic        s_dev, s_trdy, s_stop, d_dev, d_trdy, d_stop, e_dev;
    logic [31:0] s_rd;

    cfg_target dut (
        .clk(clk), .rst(rst), .init_done(init_done), .idsel(idsel),
        .frame(frame), .irdy(irdy), .cbe(cbe), .ad_in(ad_in),
        .ad_out(ad_out), .trdy(trdy), .stop(stop), .devsel(devsel)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] wmask(input int idx);
        if (idx == 1) return 32'h0000_0547;
        if (idx == 4 || idx == 5) return 32'hFFFF_F000;
        return 32'h0;
    endfunction

    function automatic logic [31:0] lanes(input logic [3:0] be_n);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) m[8*k +: 8] = be_n[k] ? 8'h00 : 8'hFF;
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: address phase, data phase, optional burst continuation, end
    task automatic access(input logic sel, input logic [3:0] cmd, input logic [7:0] addr,
                          input logic [3:0] be_n, input logic [31:0] wd, input bit burst);
        @(negedge clk);
        frame = 1'b1; irdy = 1'b0; idsel = sel; cbe = cmd; ad_in = {24'hC3A55A, addr};
        @(negedge clk);
        idsel = 1'b0; cbe = be_n; ad_in = wd; irdy = 1'b1; frame = burst;
        #1;
        s_dev = devsel; s_trdy = trdy; s_stop = stop; s_rd = ad_out;
        d_dev = 1'b0; d_trdy = 1'b0; d_stop = 1'b0;
        if (burst) begin
            @(negedge clk);
            #1;
            d_dev = devsel; d_trdy = trdy; d_stop = stop;
            frame = 1'b0; irdy = 1'b1;
        end
        @(negedge clk);
        frame = 1'b0; irdy = 1'b0; cbe = 4'hF;
        #1;
        e_dev = devsel;
    endtask

    task automatic do_write(input int idx, input logic [3:0] be_n, input logic [31:0] wd);
        access(1'b1, WR, 8'(idx << 2), be_n, wd, 1'b0);
        model[idx] = (model[idx] & ~(wmask(idx) & lanes(be_n))) | (wd & wmask(idx) & lanes(be_n));
    endtask

    task automatic read_check(input int idx, input logic [3:0] be_n, input string req);
        access(1'b1, RD, 8'(idx << 2), be_n, 32'hDEAD_BEEF, 1'b0);
        check({req, " read trdy"}, 32'(s_trdy), 32'd1);
        check({req, $sformatf(" read dword %0d", idx)}, s_rd, (idx == 0) ? ID_WORD : model[idx]);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        // R11: outputs idle in reset
        check("R11 devsel in reset", 32'(devsel), 0);
        check("R11 trdy in reset", 32'(trdy), 0);
        check("R11 stop in reset", 32'(stop), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: retry while initialization incomplete, no writes
        foreach (model[i]) if (i == 1 || i == 4 || i == 5 || i == 0) begin
            access(1'b1, WR, 8'(i << 2), 4'h0, 32'hFFFF_FFFF, 1'b0);
            check("R1 retry devsel", 32'(s_dev), 1);
            check("R1 retry stop", 32'(s_stop), 1);
            check("R1 retry no trdy", 32'(s_trdy), 0);
            check("R1 retry released", 32'(e_dev), 0);
        end
        access(1'b1, RD, 8'h00, 4'h0, 32'h0, 1'b0);
        check("R1 read retry stop", 32'(s_stop), 1);
        check("R1 read retry no trdy", 32'(s_trdy), 0);

        init_done = 1'b1;

        // R2 R4 R6 R7 R10 R11: full read sweep, byte enables varied
        for (int i = 0; i < 64; i++) begin
            read_check(i, 4'(i), "R6/R7/R11");
            check("R2 devsel", 32'(s_dev), 1);
            check("R2 no stop on single", 32'(s_stop), 0);
        end

        // R8 R9 R10 R4: write sweep of every dword with every lane pattern
        for (int i = 0; i < 64; i++) begin
            for (int be = 0; be < 16; be++) begin
                logic [31:0] wd;
                wd = (32'(i) * 32'h0101_0101) ^ (32'(be) * 32'h1111_1111) ^ 32'hA5C3_5A3C;
                do_write(i, 4'(be), wd);
                check("R2 write trdy", 32'(s_trdy), 1);
                read_check(i, 4'hF - 4'(be), (i == 0 || wmask(i) == 0) ? "R9" : "R8/R10");
            end
        end

        // R5: burst write disconnects, only first dword lands
        access(1'b1, WR, 8'h10, 4'h0, 32'h1234_5FFF, 1'b1);
        model[4] = 32'h1234_5000;
        check("R5 stop with trdy", {30'h0, s_trdy, s_stop}, 32'h3);
        check("R5 disconnect hold", {29'h0, d_dev, d_trdy, d_stop}, 32'h5);
        check("R5 released", 32'(e_dev), 0);
        read_check(4, 4'h0, "R5");
        read_check(5, 4'h0, "R5");
        access(1'b1, RD, 8'h04, 4'h0, 32'h0, 1'b1);
        check("R5 burst read data", s_rd, model[1]);
        check("R5 burst read stop", {30'h0, s_trdy, s_stop}, 32'h3);

        // R3: cycles that must not be claimed
        access(1'b0, WR, 8'h04, 4'h0, 32'hFFFF_FFFF, 1'b0);
        check("R3 idsel low", {29'h0, s_dev, s_trdy, s_stop}, 0);
        for (int t = 1; t < 4; t++) begin
            access(1'b1, WR, 8'h14 | 8'(t), 4'h0, 32'h0000_0000, 1'b0);
            check("R3 type bits nonzero", {29'h0, s_dev, s_trdy, s_stop}, 0);
        end
        for (int c = 0; c < 16; c++) begin
            if (4'(c) != RD && 4'(c) != WR) begin
                access(1'b1, 4'(c), 8'h10, 4'h0, 32'h0, 1'b0);
                check("R3 other command", {29'h0, s_dev, s_trdy, s_stop}, 0);
            end
        end
        read_check(1, 4'h0, "R3");
        read_check(4, 4'h0, "R3");
        read_check(5, 4'h0, "R3");

        // R1: retry again after clearing init_done, state unchanged
        init_done = 1'b0;
        access(1'b1, WR, 8'h14, 4'h0, 32'h0, 1'b0);
        check("R1 late retry", {29'h0, s_dev, s_trdy, s_stop}, 32'h5);
        init_done = 1'b1;
        read_check(5, 4'h0, "R1");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule